// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the device-side serial port of a small flash-style memory. A host frames each operation by pulling the active-low select line low. It then clocks in an opcode and, for addressed opcodes, a big-endian address, one bit per serial clock edge. The block brings the serial pins into the system clock domain and finds the edges of the select line and the serial clock there. It gathers bytes and sorts each opcode into one of four classes. When a command is complete it hands a one-cycle strobe with class, opcode and address to the array controller.

The controller supplies read data through a byte port, which the block shifts out with the bit changing on falling serial clock edges. Data bytes that follow an accepted write-type command are passed to the controller one byte at a time. An active-low write-protect input and a busy input from the controller can veto commands. An active-low reset aborts whatever frame is in progress. Every opcode value is a parameter, so one block serves several opcode sets.

Top module: `spi_cmd_frontend`

## Requirements
- R1: A frame starts only when the synchronised select line falls. If reset is released while select is already low, nothing is decoded until select has gone high and then low again.
- R2: While select is high, the output enable stays low (after the synchroniser delay) and serial input bits have no effect on any later frame.
- R3: Bits are taken on rising serial clock edges, MSB first. The first byte is the opcode, then three address bytes with the first byte as address bits 23:16. The command strobe is a one-cycle pulse carrying class, opcode and address. The class encoding is 0 read, 1 program/erase, 2 protection control, 3 other.
- R4: An opcode that belongs to no parameter set gives a strobe of class 3 with address 0 right after the opcode byte, and the rest of that frame is ignored.
- R5: After a read strobe the output enable rises. On each falling serial clock edge the output moves one bit, MSB first. At the first falling edge of each byte the block latches `rd_byte` and pulses `rd_take`.
- R6: Both clock polarities work, with the serial clock idle low (mode 0) or idle high (mode 3) when select falls.
- R7: A program/erase command that completes while write-protect is low gives no strobe and no write data. The next frame decodes normally.
- R8: The protection-enable and lockdown opcodes give a class 2 strobe even while write-protect is low.
- R9: The opcodes that write the protection register are dropped while write-protect is low. When write-protect is high they give a class 2 strobe followed by write data.
- R10: A program/erase command that completes while the busy input is high is dropped.
- R11: Each whole byte after an accepted program/erase or protection-register write command shows up once, in order, on `wr_data` with a one-cycle `wr_valid`.
- R12: While reset is low, all strobes and the output enable are low, and any frame in progress is abandoned.
- R13: Select rising in mid-byte or mid-address discards the partial command without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low reset, aborts frames |
| sel_n | input | 1 | Active-low frame select from host |
| sclk | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out to host |
| miso_oe | output | 1 | Output enable for `miso` |
| wprot_n | input | 1 | Active-low write-protect |
| array_busy | input | 1 | Array controller busy |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_class | output | 2 | Command class |
| cmd_opcode | output | 8 | Opcode of the command |
| cmd_addr | output | 24 | Command address |
| wr_valid | output | 1 | Write data byte strobe |
| wr_data | output | 8 | Write data byte |
| rd_byte | input | 8 | Next read byte from the controller |
| rd_take | output | 1 | Pulses when `rd_byte` has been latched |

## Verification
The bench goes after reset released with select already low. A design that keys frames on the select level instead of its falling edge would decode those stray bits as a command. Program, protection-register writes and lockdown opcodes are sent with write-protect low. A design that blocks too little issues array writes, and one that blocks too much loses the lockdown strobe. Frames cut off mid-address, and bits clocked while select is high, would leave a careless design with a shifted bit counter, so every later command would be garbled. Reads are run in both clock polarities, and an off-by-one in the output shifter shows up as a rotated data byte.

// File: rtl/spi_fe_pkg.sv
`timescale 1ns/1ps
package spi_fe_pkg;

   typedef enum logic [1:0] {
      CLS_READ  = 2'd0,
      CLS_PGM   = 2'd1,
      CLS_PROT  = 2'd2,
      CLS_OTHER = 2'd3
   } op_class_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_WDATA,
      ST_TX,
      ST_DROP
   } fe_state_e;

endpackage

// File: rtl/spi_fe_sync.sv
`timescale 1ns/1ps
module spi_fe_sync #(
   parameter int                WIDTH   = 1,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_fe_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spi_fe_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      end else begin
         pipe[0] <= d_in;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_fe_decode.sv
`timescale 1ns/1ps
module spi_fe_decode
   import spi_fe_pkg::*;
#(
   parameter int                  N_RD   = 2,
   parameter logic [N_RD*8-1:0]   RD_OPS = 16'h0B03,
   parameter int                  N_PE   = 3,
   parameter logic [N_PE*8-1:0]   PE_OPS = 24'h208182,
   parameter int                  N_PW   = 2,
   parameter logic [N_PW*8-1:0]   PW_OPS = 16'h3B3A,
   parameter int                  N_PK   = 2,
   parameter logic [N_PK*8-1:0]   PK_OPS = 16'h3D3C
) (
   input  logic [7:0] opcode,
   output op_class_e  cls,
   output logic       prot_wr
);

   if (N_RD < 1 || N_PE < 1 || N_PW < 1 || N_PK < 1) begin : g_bad_sets
      $error("spi_fe_decode: every opcode set needs at least one entry");
   end

   logic [N_RD-1:0] hit_rd;
   logic [N_PE-1:0] hit_pe;
   logic [N_PW-1:0] hit_pw;
   logic [N_PK-1:0] hit_pk;

   for (genvar g = 0; g < N_RD; g++) begin : g_rd
      assign hit_rd[g] = (opcode == RD_OPS[g*8 +: 8]);
   end
   for (genvar g = 0; g < N_PE; g++) begin : g_pe
      assign hit_pe[g] = (opcode == PE_OPS[g*8 +: 8]);
   end
   for (genvar g = 0; g < N_PW; g++) begin : g_pw
      assign hit_pw[g] = (opcode == PW_OPS[g*8 +: 8]);
   end
   for (genvar g = 0; g < N_PK; g++) begin : g_pk
      assign hit_pk[g] = (opcode == PK_OPS[g*8 +: 8]);
   end

   // Priority: read, program/erase, protection write, protection keep.
   always_comb begin
      prot_wr = 1'b0;
      if (|hit_rd)      cls = CLS_READ;
      else if (|hit_pe) cls = CLS_PGM;
      else if (|hit_pw) begin
         cls     = CLS_PROT;
         prot_wr = 1'b1;
      end
      else if (|hit_pk) cls = CLS_PROT;
      else              cls = CLS_OTHER;
   end

endmodule

// File: rtl/spi_fe_txshift.sv
`timescale 1ns/1ps
module spi_fe_txshift #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            shift_edge,
   input  logic [BITS-1:0] load_val,
   output logic            ser_out,
   output logic            load_pulse
);

   localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;

   if (BITS < 2) begin : g_bad_bits
      $error("spi_fe_txshift: BITS must be at least 2");
   end

   logic [BITS-1:0] sr;
   logic [CW-1:0]   cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr         <= '0;
         cnt        <= '0;
         load_pulse <= 1'b0;
      end else begin
         load_pulse <= 1'b0;
         if (!en) begin
            cnt <= '0;
         end else if (shift_edge) begin
            if (cnt == '0) begin
               sr         <= load_val;
               load_pulse <= 1'b1;
            end else begin
               sr <= {sr[BITS-2:0], 1'b0};
            end
            cnt <= (cnt == CW'(BITS-1)) ? '0 : CW'(cnt + 1'b1);
         end
      end
   end

   assign ser_out = sr[BITS-1];

endmodule

// File: rtl/spi_cmd_frontend.sv
`timescale 1ns/1ps
module spi_cmd_frontend
   import spi_fe_pkg::*;
#(
   parameter int                  ADDR_BYTES  = 3,
   parameter int                  SYNC_STAGES = 2,
   parameter int                  N_RD   = 2,
   parameter logic [N_RD*8-1:0]   RD_OPS = 16'h0B03,
   parameter int                  N_PE   = 3,
   parameter logic [N_PE*8-1:0]   PE_OPS = 24'h208182,
   parameter int                  N_PW   = 2,
   parameter logic [N_PW*8-1:0]   PW_OPS = 16'h3B3A,
   parameter int                  N_PK   = 2,
   parameter logic [N_PK*8-1:0]   PK_OPS = 16'h3D3C,
   localparam int                 ADDR_W = 8 * ADDR_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              sclk,
   input  logic              mosi,
   output logic              miso,
   output logic              miso_oe,
   input  logic              wprot_n,
   input  logic              array_busy,
   output logic              cmd_valid,
   output logic [1:0]        cmd_class,
   output logic [7:0]        cmd_opcode,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              wr_valid,
   output logic [7:0]        wr_data,
   input  logic [7:0]        rd_byte,
   output logic              rd_take
);

   localparam int ABW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

   if (ADDR_BYTES < 2 || ADDR_BYTES > 4) begin : g_bad_addr
      $error("spi_cmd_frontend: ADDR_BYTES must be 2 to 4");
   end

   // Synchronised pins: {sel_n, sclk, mosi, wprot_n}. Reset low so that a
   // select line already low at reset release produces no falling edge.
   logic [3:0] pins_s;
   logic       sel_s, sclk_s, mosi_s, wp_s;

   spi_fe_sync #(
      .WIDTH   (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b0000)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({sel_n, sclk, mosi, wprot_n}),
      .q     (pins_s)
   );

   assign {sel_s, sclk_s, mosi_s, wp_s} = pins_s;

   logic sel_p, sclk_p;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_p  <= 1'b0;
         sclk_p <= 1'b0;
      end else begin
         sel_p  <= sel_s;
         sclk_p <= sclk_s;
      end
   end

   logic sel_fall, sclk_rise, sclk_fall;
   assign sel_fall  = sel_p & ~sel_s;
   assign sclk_rise = ~sclk_p & sclk_s;
   assign sclk_fall = sclk_p & ~sclk_s;

   // Frame state and byte assembly
   fe_state_e        state;
   logic [2:0]       bit_cnt;
   logic [6:0]       rx_sr;
   logic [7:0]       rx_byte_w;
   logic [7:0]       opc_q;
   op_class_e        cls_q;
   logic             pw_q;
   logic [ADDR_W-9:0] addr_q;
   logic [ADDR_W-1:0] addr_next;
   logic [ABW-1:0]   abyte_cnt;
   op_class_e        cls_r;
   logic             shifting;
   logic             byte_done;
   op_class_e        dec_cls;
   logic             dec_pw;
   logic             veto;

   assign rx_byte_w = {rx_sr, mosi_s};
   assign addr_next = {addr_q, rx_byte_w};
   assign shifting  = (state == ST_OPC) || (state == ST_ADDR) || (state == ST_WDATA);
   assign byte_done = shifting && sclk_rise && (bit_cnt == 3'd7);

   spi_fe_decode #(
      .N_RD (N_RD), .RD_OPS (RD_OPS),
      .N_PE (N_PE), .PE_OPS (PE_OPS),
      .N_PW (N_PW), .PW_OPS (PW_OPS),
      .N_PK (N_PK), .PK_OPS (PK_OPS)
   ) u_dec (
      .opcode  (rx_byte_w),
      .cls     (dec_cls),
      .prot_wr (dec_pw)
   );

   always_comb begin
      veto = 1'b0;
      if (cls_q == CLS_PGM && (!wp_s || array_busy)) veto = 1'b1;
      if (cls_q == CLS_PROT && pw_q && !wp_s)        veto = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= '0;
         rx_sr      <= '0;
         opc_q      <= '0;
         cls_q      <= CLS_OTHER;
         pw_q       <= 1'b0;
         addr_q     <= '0;
         abyte_cnt  <= '0;
         cmd_valid  <= 1'b0;
         cls_r      <= CLS_READ;
         cmd_opcode <= '0;
         cmd_addr   <= '0;
         wr_valid   <= 1'b0;
         wr_data    <= '0;
      end else begin
         cmd_valid <= 1'b0;
         wr_valid  <= 1'b0;
         if (sel_fall) begin
            state   <= ST_OPC;
            bit_cnt <= '0;
         end else if (sel_s) begin
            state <= ST_IDLE;
         end else if (shifting && sclk_rise) begin
            bit_cnt <= 3'(bit_cnt + 3'd1);
            rx_sr   <= rx_byte_w[6:0];
            if (byte_done) begin
               unique case (state)
                  ST_OPC: begin
                     opc_q     <= rx_byte_w;
                     cls_q     <= dec_cls;
                     pw_q      <= dec_pw;
                     abyte_cnt <= '0;
                     if (dec_cls == CLS_OTHER) begin
                        cmd_valid  <= 1'b1;
                        cls_r      <= CLS_OTHER;
                        cmd_opcode <= rx_byte_w;
                        cmd_addr   <= '0;
                        state      <= ST_DROP;
                     end else begin
                        state <= ST_ADDR;
                     end
                  end
                  ST_ADDR: begin
                     addr_q <= addr_next[ADDR_W-9:0];
                     if (abyte_cnt == ABW'(ADDR_BYTES-1)) begin
                        if (veto) begin
                           state <= ST_DROP;
                        end else begin
                           cmd_valid  <= 1'b1;
                           cls_r      <= cls_q;
                           cmd_opcode <= opc_q;
                           cmd_addr   <= addr_next;
                           if (cls_q == CLS_READ)                      state <= ST_TX;
                           else if (cls_q == CLS_PGM || pw_q)          state <= ST_WDATA;
                           else                                        state <= ST_DROP;
                        end
                     end else begin
                        abyte_cnt <= ABW'(abyte_cnt + 1'b1);
                     end
                  end
                  ST_WDATA: begin
                     wr_valid <= 1'b1;
                     wr_data  <= rx_byte_w;
                  end
                  default: state <= ST_DROP;
               endcase
            end
         end
      end
   end

   assign cmd_class = cls_r;
   assign miso_oe   = (state == ST_TX);

   spi_fe_txshift #(
      .BITS (8)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (miso_oe),
      .shift_edge (sclk_fall),
      .load_val   (rd_byte),
      .ser_out    (miso),
      .load_pulse (rd_take)
   );

endmodule

// File: rtl/spi_cmd_frontend_chk.sv
`timescale 1ns/1ps
module spi_cmd_frontend_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sel_n,
   input logic       miso_oe,
   input logic       cmd_valid,
   input logic [1:0] cmd_class,
   input logic       wr_valid,
   input logic       rd_take,
   input logic       array_busy,
   input logic       wp_s
);

   // R2
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n && $past(sel_n) && $past(sel_n, 2) && $past(sel_n, 3)) |-> !miso_oe);

   // R3
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R7
   wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_class == 2'd1) |-> $past(wp_s));

   // R10
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_class == 2'd1) |-> !$past(array_busy));

   // R5
   take_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_take |-> $past(miso_oe));

   // R11
   wdata_not_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !miso_oe);

   // R3
   one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_valid, wr_valid, rd_take}));

endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_n      (sel_n),
   .miso_oe    (miso_oe),
   .cmd_valid  (cmd_valid),
   .cmd_class  (cmd_class),
   .wr_valid   (wr_valid),
   .rd_take    (rd_take),
   .array_busy (array_busy),
   .wp_s       (wp_s)
);

// File: tb/spi_cmd_frontend_tb.sv
`timescale 1ns/1ps
module spi_cmd_frontend_tb;

   localparam int H = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1;
   logic        sclk = 1'b0;
   logic        mosi = 1'b0;
   logic        wprot_n = 1'b1;
   logic        array_busy = 1'b0;
   logic        miso, miso_oe, cmd_valid, wr_valid, rd_take;
   logic [1:0]  cmd_class;
   logic [7:0]  cmd_opcode, wr_data, rd_byte;
   logic [23:0] cmd_addr;

   int vecs = 0;
   int errs = 0;
   bit done = 0;
   string cur_req = "R3";

   logic [33:0] q_cmd [$];
   logic [7:0]  q_wr  [$];

   logic [7:0] tx_seed = 8'h00;
   int         load_cnt = 0;
   int         load_base = 0;

   always #2.5 clk = ~clk;

   spi_cmd_frontend u_dut (
      .clk (clk), .rst_n (rst_n), .sel_n (sel_n), .sclk (sclk), .mosi (mosi),
      .miso (miso), .miso_oe (miso_oe), .wprot_n (wprot_n), .array_busy (array_busy),
      .cmd_valid (cmd_valid), .cmd_class (cmd_class), .cmd_opcode (cmd_opcode),
      .cmd_addr (cmd_addr), .wr_valid (wr_valid), .wr_data (wr_data),
      .rd_byte (rd_byte), .rd_take (rd_take)
   );

   // Array controller model: byte k of a read is seed + 0x37*k.
   always @(posedge clk) if (rd_take) load_cnt <= load_cnt + 1;
   assign rd_byte = 8'(tx_seed + 8'h37 * 8'(load_cnt - load_base));

   // Per-clock comparison against the expected event queues.
   int sel_hi = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         if (cmd_valid || wr_valid || miso_oe || rd_take) begin
            errs++;
            $display("FAIL R12 outputs during reset: act=%b%b%b%b exp=0000",
                     cmd_valid, wr_valid, miso_oe, rd_take);
         end
      end else begin
         if (cmd_valid) begin
            vecs++;
            if (q_cmd.size() == 0) begin
               errs++;
               $display("FAIL %s unexpected strobe: act=%h exp=none", cur_req,
                        {cmd_class, cmd_opcode, cmd_addr});
            end else begin
               logic [33:0] e;
               e = q_cmd.pop_front();
               if ({cmd_class, cmd_opcode, cmd_addr} !== e) begin
                  errs++;
                  $display("FAIL %s strobe: act=%h exp=%h", cur_req,
                           {cmd_class, cmd_opcode, cmd_addr}, e);
               end
            end
         end
         if (wr_valid) begin
            vecs++;
            if (q_wr.size() == 0) begin
               errs++;
               $display("FAIL %s unexpected write byte: act=%h exp=none", cur_req, wr_data);
            end else begin
               logic [7:0] w;
               w = q_wr.pop_front();
               if (wr_data !== w) begin
                  errs++;
                  $display("FAIL %s write byte: act=%h exp=%h", cur_req, wr_data, w);
               end
            end
         end
         sel_hi = sel_n ? sel_hi + 1 : 0;
         // R2: output enable low once deselect has passed the synchroniser
         if (sel_hi > 4 && miso_oe) begin
            errs++;
            $display("FAIL R2 miso_oe while deselected: act=1 exp=0");
         end
      end
   end

   task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) begin
         sclk = 1'b0;
         mosi = b[i];
         repeat (H) @(negedge clk);
         sclk = 1'b1;
         r[i] = miso;
         repeat (H) @(negedge clk);
      end
   endtask

   task automatic frame_begin(input bit m3);
      sclk = m3;
      repeat (4) @(negedge clk);
      sel_n = 1'b0;
      repeat (H) @(negedge clk);
   endtask

   task automatic frame_end(input bit m3);
      if (!m3) begin
         sclk = 1'b0;
         repeat (H) @(negedge clk);
      end
      sel_n = 1'b1;
      repeat (2 * H) @(negedge clk);
   endtask

   task automatic drained(input string tag);
      repeat (4) @(negedge clk);
      vecs++;
      if (q_cmd.size() != 0 || q_wr.size() != 0) begin
         errs++;
         $display("FAIL %s missing events: act=0 exp=%0d cmd/%0d wr", tag,
                  q_cmd.size(), q_wr.size());
         q_cmd.delete();
         q_wr.delete();
      end
   endtask

   task automatic frame(input bit m3, input int n, input logic [63:0] pl,
                        input int nrd, input logic [7:0] seed, input string tag);
      logic [7:0] r;
      cur_req   = tag;
      tx_seed   = seed;
      load_base = load_cnt;
      frame_begin(m3);
      for (int i = 0; i < n; i++) spi_byte(pl[8*(n-1-i) +: 8], r);
      for (int k = 0; k < nrd; k++) begin
         logic [7:0] exp_b;
         spi_byte(8'h00, r);
         exp_b = 8'(seed + 8'h37 * 8'(k));
         vecs++;
         if (r !== exp_b) begin
            errs++;
            $display("FAIL %s read byte %0d: act=%h exp=%h", tag, k, r, exp_b);
         end
      end
      frame_end(m3);
      drained(tag);
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: act=timeout exp=finish");
      report();
   end

   initial begin
      logic [7:0] r;
      repeat (6) @(negedge clk);
      // R12: reset state
      vecs++;
      if (cmd_valid || wr_valid || miso_oe || rd_take) begin
         errs++;
         $display("FAIL R12 reset state: act=%b%b%b%b exp=0000",
                  cmd_valid, wr_valid, miso_oe, rd_take);
      end
      rst_n = 1'b1;
      repeat (6) @(negedge clk);

      // R3 R5: mode 0 read with address fields in order
      q_cmd.push_back({2'd0, 8'h03, 24'h123456});
      frame(1'b0, 4, 64'h03123456, 3, 8'hA5, "R5");

      // R6: mode 3 read
      q_cmd.push_back({2'd0, 8'h0B, 24'hABCDEF});
      frame(1'b1, 4, 64'h0BABCDEF, 2, 8'h3C, "R6");

      // R11: accepted program with data bytes
      q_cmd.push_back({2'd1, 8'h82, 24'h000100});
      q_wr.push_back(8'hDE); q_wr.push_back(8'hAD);
      q_wr.push_back(8'hBE); q_wr.push_back(8'hEF);
      frame(1'b0, 8, 64'h82000100DEADBEEF, 0, 8'h00, "R11");

      // R4: unknown opcode, trailing bytes ignored
      q_cmd.push_back({2'd3, 8'h9F, 24'h000000});
      frame(1'b1, 3, 64'h9F5555, 0, 8'h00, "R4");

      // R7: program under write-protect dropped, then next frame decodes
      wprot_n = 1'b0;
      repeat (4) @(negedge clk);
      frame(1'b0, 6, 64'h20070000_1122, 0, 8'h00, "R7");
      q_cmd.push_back({2'd0, 8'h03, 24'h00FF01});
      frame(1'b0, 4, 64'h0300FF01, 1, 8'h11, "R7");

      // R8: protection enable and lockdown still accepted
      q_cmd.push_back({2'd2, 8'h3C, 24'h000000});
      frame(1'b0, 4, 64'h3C000000, 0, 8'h00, "R8");
      q_cmd.push_back({2'd2, 8'h3D, 24'h010000});
      frame(1'b1, 5, 64'h3D01000077, 0, 8'h00, "R8");

      // R9: protection register write dropped, then accepted
      frame(1'b0, 5, 64'h3A00000033, 0, 8'h00, "R9");
      wprot_n = 1'b1;
      repeat (4) @(negedge clk);
      q_cmd.push_back({2'd2, 8'h3B, 24'h000002});
      q_wr.push_back(8'h5A);
      frame(1'b0, 5, 64'h3B0000025A, 0, 8'h00, "R9");

      // R10: busy drops program, cleared busy accepts
      array_busy = 1'b1;
      frame(1'b0, 5, 64'h81004000C3, 0, 8'h00, "R10");
      array_busy = 1'b0;
      q_cmd.push_back({2'd1, 8'h81, 24'h004000});
      q_wr.push_back(8'hC3);
      frame(1'b0, 5, 64'h81004000C3, 0, 8'h00, "R10");

      // R2: clocks while deselected are ignored
      cur_req = "R2";
      for (int i = 0; i < 21; i++) begin
         sclk = 1'b0; mosi = i[0];
         repeat (H) @(negedge clk);
         sclk = 1'b1;
         repeat (H) @(negedge clk);
      end
      drained("R2");
      q_cmd.push_back({2'd0, 8'h03, 24'h0A0B0C});
      frame(1'b0, 4, 64'h030A0B0C, 1, 8'h42, "R2");

      // R13: select rises mid-address
      cur_req = "R13";
      frame_begin(1'b0);
      spi_byte(8'h03, r);
      spi_byte(8'h12, r);
      for (int i = 0; i < 4; i++) begin
         sclk = 1'b0; mosi = 1'b1;
         repeat (H) @(negedge clk);
         sclk = 1'b1;
         repeat (H) @(negedge clk);
      end
      frame_end(1'b0);
      drained("R13");
      q_cmd.push_back({2'd3, 8'hE7, 24'h000000});
      frame(1'b0, 1, 64'hE7, 0, 8'h00, "R13");

      // R12 R1: reset mid-frame, select stays low afterwards
      cur_req = "R12";
      frame_begin(1'b0);
      spi_byte(8'h82, r);
      spi_byte(8'h00, r);
      rst_n = 1'b0;
      repeat (6) @(negedge clk);
      vecs++;
      if (cmd_valid || wr_valid || miso_oe || rd_take) begin
         errs++;
         $display("FAIL R12 abort: act=%b%b%b%b exp=0000",
                  cmd_valid, wr_valid, miso_oe, rd_take);
      end
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      cur_req = "R1";
      spi_byte(8'h03, r);
      spi_byte(8'h00, r);
      spi_byte(8'h00, r);
      spi_byte(8'h10, r);
      spi_byte(8'h00, r);
      vecs++;
      if (miso_oe) begin
         errs++;
         $display("FAIL R1 frame decoded without select edge: act=1 exp=0");
      end
      frame_end(1'b0);
      drained("R1");
      q_cmd.push_back({2'd0, 8'h03, 24'h000010});
      frame(1'b1, 4, 64'h03000010, 2, 8'h90, "R1");

      report();
   end

endmodule